// File: doc/BRIEF.md
# Incremental Frequency Compensation Loop

This block sits beside the phase-tracking loop of a clock and data recovery path and removes a slowly moving frequency offset, such as one caused by spread-spectrum clocking. It watches the lead and lag correction pulses that the loop filter issues. Over each fixed window of 512 clock cycles it forms their net count. At the end of the window it adds that count into a running frequency estimate. During the next window it replays that estimate as a stream of single-step correction pulses, spread as evenly as the window allows.

The estimate changes by one window's worth of net error at a time, so the compensation follows a linear frequency ramp in steps. The residual error that the phase loop must absorb stays small. A positive estimate produces lead corrections and a negative one produces lag corrections. Each output pulse asks the phase control for one resolution step. Windows are counted from the release of reset. The window length is two to the power of the prescale width plus the rate width.

Top module: `incr_freq_comp`

## Requirements
- R1: While reset is held both correction outputs are low, and after release the running estimate is zero, so the first window emits no pulse.
- R2: A window lasts 512 cycles, counted from the first cycle after reset release. Within a window the net counter rises by one for each cycle with only leadIn high and falls by one for each cycle with only lagIn high. A cycle with both inputs high or both low leaves it unchanged.
- R3: The net counter saturates at +127 and -127 and never wraps.
- R4: The net count, including the input of a window's last cycle, is added into the running estimate when that window ends. The net counter then restarts from zero, and the estimate does not change at any other time.
- R5: The running estimate is signed and saturates at +127 and -127.
- R6: During each window the block emits exactly as many pulses as the magnitude of the estimate held in that window. It uses corrLead when the estimate is positive, corrLag when it is negative, and no pulse when it is zero.
- R7: corrLead and corrLag are never high in the same cycle.
- R8: Pulses are spaced by binary rate multiplication. A tick falls on window cycles 3, 7, 11 and so on, giving 128 ticks numbered t = 0..127. When t counts up to t+1, let k be the lowest bit that goes from 0 to 1. A pulse is issued in the cycle after tick t if magnitude bit 6-k is set. So a magnitude of 64 gives pulses at window cycles 4, 12, 20 and onward, 8 apart. A magnitude of 1 gives a single pulse in window cycle 256, and 127 gives a pulse every 4 cycles from cycle 4.
- R9: Every correction pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leadIn | input | 1 | Lead decision from the loop filter, one per cycle |
| lagIn | input | 1 | Lag decision from the loop filter, one per cycle |
| corrLead | output | 1 | One-step lead correction pulse |
| corrLag | output | 1 | One-step lag correction pulse |

## Verification
A wrong window count or a lost boundary sample shows up as a wrong pulse total in the window that follows, so the fault appears at the ports within one window. A wrong sign or a missed saturation appears as pulses on the wrong output, or as a total other than 127, and it persists for every later window because the estimate integrates. Faults in the spacing logic move the position of the first pulse and change the gap between pulses. The bench checks these directly for magnitudes 1, 64 and 127, so a mapping error shows within a few dozen cycles of the window start.

// File: rtl/fcomp_pkg.sv
package fcomp_pkg;

  // width of the rate counter that spreads pulses across one window
  localparam int FC_RATE_W = 7;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic                 winEnd;  // last cycle of the window
    logic                 tick;    // prescaled tick
    logic [FC_RATE_W-1:0] rise;    // one-hot: lowest bit rising on this tick
  } fcStrb_t;

endpackage

// File: rtl/fcomp_ctrl.sv
module fcomp_ctrl
  import fcomp_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int RATE_W = FC_RATE_W
) (
  input  logic    clk,
  input  logic    rst_n,
  output fcStrb_t strb
);

  logic [PRE_W-1:0]  preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic [RATE_W-1:0] onesBelow;
  logic [RATE_W-1:0] riseRaw;
  logic              tick;

  // prescaler: one tick every 2**PRE_W cycles, on the last count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) preCnt <= '0;
    else        preCnt <= preCnt + 1'b1;
  end

  assign tick = &preCnt;

  // rate counter advances once per tick and wraps once per window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rateCnt <= '0;
    else if (tick) rateCnt <= rateCnt + 1'b1;
  end

  // lowest zero bit of rateCnt is the bit that rises on the increment
  assign onesBelow[0] = 1'b1;
  assign riseRaw[0]   = ~rateCnt[0];
  for (genvar k = 1; k < RATE_W; k++) begin : g_rise
    assign onesBelow[k] = onesBelow[k-1] & rateCnt[k-1];
    assign riseRaw[k]   = ~rateCnt[k] & onesBelow[k];
  end

  assign strb.tick   = tick;
  assign strb.winEnd = tick & (&rateCnt);
  assign strb.rise   = tick ? riseRaw : '0;

endmodule

// File: rtl/fcomp_dp.sv
module fcomp_dp
  import fcomp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int RATE_W = FC_RATE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  fcStrb_t                 strb,
  input  logic                    leadIn,
  input  logic                    lagIn,
  output logic signed [CNT_W-1:0] netCnt,
  output logic signed [CNT_W-1:0] accVal,
  output logic                    corrLead,
  output logic                    corrLag
);

  localparam int LIM = (1 << RATE_W) - 1;
  localparam logic signed [CNT_W:0]   SLIM  = (CNT_W+1)'(LIM);
  localparam logic signed [CNT_W-1:0] LIMP  = CNT_W'(LIM);
  localparam logic signed [CNT_W-1:0] LIMN  = -LIMP;

  function automatic logic signed [CNT_W-1:0] satAdd(
    input logic signed [CNT_W-1:0] a,
    input logic signed [CNT_W-1:0] b
  );
    logic signed [CNT_W:0] s;
    s = {a[CNT_W-1], a} + {b[CNT_W-1], b};
    if (s > SLIM)       return LIMP;
    else if (s < -SLIM) return LIMN;
    else                return s[CNT_W-1:0];
  endfunction

  logic signed [CNT_W-1:0] step;
  logic signed [CNT_W-1:0] netNext;
  logic        [CNT_W-1:0] absVal;
  logic        [RATE_W-1:0] mag;
  logic        [RATE_W-1:0] gated;
  logic                     fire;

  always_comb begin
    if (leadIn && !lagIn)      step = CNT_W'(1);
    else if (lagIn && !leadIn) step = '1;
    else                       step = '0;
  end

  assign netNext = satAdd(netCnt, step);

  // window up/down counter; cleared once its value is handed over
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           netCnt <= '0;
    else if (strb.winEnd) netCnt <= '0;
    else                  netCnt <= netNext;
  end

  // running estimate, updated only at the window boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           accVal <= '0;
    else if (strb.winEnd) accVal <= satAdd(accVal, netNext);
  end

  // magnitude of the estimate, clamped to the rate range
  always_comb begin
    absVal = accVal[CNT_W-1] ? (~accVal + 1'b1) : accVal;
    if (absVal > CNT_W'(LIM)) mag = RATE_W'(LIM);
    else                      mag = absVal[RATE_W-1:0];
  end

  // rate bit k pairs with magnitude bit RATE_W-1-k
  for (genvar k = 0; k < RATE_W; k++) begin : g_brm
    assign gated[k] = strb.rise[k] & mag[RATE_W-1-k];
  end

  assign fire = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrLead <= 1'b0;
      corrLag  <= 1'b0;
    end else begin
      corrLead <= fire & ~accVal[CNT_W-1];
      corrLag  <= fire &  accVal[CNT_W-1];
    end
  end

endmodule

// File: rtl/incr_freq_comp.sv
module incr_freq_comp
  import fcomp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 2,
  parameter int RATE_W = FC_RATE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic leadIn,
  input  logic lagIn,
  output logic corrLead,
  output logic corrLag
);

  fcStrb_t                 strb;
  logic signed [CNT_W-1:0] netCnt;
  logic signed [CNT_W-1:0] accVal;
  logic                    winEndS;
  logic                    tickS;

  fcomp_ctrl #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb)
  );

  fcomp_dp #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .leadIn   (leadIn),
    .lagIn    (lagIn),
    .netCnt   (netCnt),
    .accVal   (accVal),
    .corrLead (corrLead),
    .corrLag  (corrLag)
  );

  assign winEndS = strb.winEnd;
  assign tickS   = strb.tick;

endmodule

// File: rtl/incr_freq_comp_chk.sv
module incr_freq_comp_chk #(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    winEndS,
  input logic                    tickS,
  input logic signed [CNT_W-1:0] netCnt,
  input logic signed [CNT_W-1:0] accVal,
  input logic                    corrLead,
  input logic                    corrLag
);

  localparam logic signed [CNT_W-1:0] LIMS = CNT_W'((1 << RATE_W) - 1);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(corrLead && corrLag));

  p_lead_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    corrLead |=> !corrLead);

  p_lag_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    corrLag |=> !corrLag);

  p_net_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (netCnt <= LIMS) && (netCnt >= -LIMS));

  p_acc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accVal <= LIMS) && (accVal >= -LIMS));

  p_net_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    winEndS |=> (netCnt == '0));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !winEndS |=> $stable(accVal));

  p_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (corrLead || corrLag) |-> $past(tickS));

  p_lead_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corrLead |-> ($signed($past(accVal)) > 0));

  p_lag_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corrLag |-> ($signed($past(accVal)) < 0));

endmodule

bind incr_freq_comp incr_freq_comp_chk #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .winEndS  (winEndS),
  .tickS    (tickS),
  .netCnt   (netCnt),
  .accVal   (accVal),
  .corrLead (corrLead),
  .corrLag  (corrLag)
);

// File: tb/test_incr_freq_comp.sv
module test_incr_freq_comp;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 512;
  localparam int LIM        = 127;

  typedef struct {
    int    nLead;
    int    nLag;
    int    first;
    int    gap;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic leadIn = 1'b0;
  logic lagIn = 1'b0;
  logic corrLead;
  logic corrLag;

  int checks = 0;
  int errors = 0;
  int kCnt = 0;
  int accModel = 0;
  int winIdx = 0;
  expItem_t expQ[$];

  // monitor state
  int mLead = 0, mLag = 0, mFirst = -1, mLast = -1, mMinGap = 9999, mMaxGap = 0;
  int bothErr = 0, widthErr = 0;
  logic prevLead = 1'b0, prevLag = 1'b0;

  incr_freq_comp i_incr_freq_comp (
    .clk      (clk),
    .rst_n    (rst_n),
    .leadIn   (leadIn),
    .lagIn    (lagIn),
    .corrLead (corrLead),
    .corrLag  (corrLag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) kCnt <= kCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > LIM)  return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  function automatic expItem_t mkExp(input int acc, input string tag);
    expItem_t e;
    int m;
    m = (acc < 0) ? -acc : acc;
    e.nLead = (acc > 0) ? m : 0;
    e.nLag  = (acc < 0) ? m : 0;
    e.first = -1;
    e.gap   = 0;
    if (m == 64)  begin e.first = 4;   e.gap = 8; end
    if (m == 1)   begin e.first = 256; e.gap = 0; end
    if (m == LIM) begin e.first = 4;   e.gap = 4; end
    e.tag = tag;
    return e;
  endfunction

  // driver: one window of stimulus, then expectation for the next window
  task automatic runWindow(input int nLead, input int nLag, input int nBoth,
                           input bit leadLast, input string nextTag);
    int net;
    for (int i = 0; i < WIN; i++) begin
      leadIn = 1'b0;
      lagIn  = 1'b0;
      if (i < nLead) leadIn = 1'b1;
      else if (i < nLead + nLag) lagIn = 1'b1;
      else if (i < nLead + nLag + nBoth) begin leadIn = 1'b1; lagIn = 1'b1; end
      if (leadLast && i == WIN - 1) leadIn = 1'b1;
      @(negedge clk);
    end
    net = sat(nLead - nLag + (leadLast ? 1 : 0));
    accModel = sat(accModel + net);
    expQ.push_back(mkExp(accModel, nextTag));
  endtask

  // monitor: counts pulses per window and compares at the window's last cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int pos;
      pos = kCnt % WIN;
      if (corrLead && corrLag) bothErr++;
      if ((corrLead && prevLead) || (corrLag && prevLag)) widthErr++;
      prevLead = corrLead;
      prevLag  = corrLag;
      if (corrLead) mLead++;
      if (corrLag)  mLag++;
      if (corrLead || corrLag) begin
        if (mFirst < 0) mFirst = pos;
        else begin
          if (pos - mLast < mMinGap) mMinGap = pos - mLast;
          if (pos - mLast > mMaxGap) mMaxGap = pos - mLast;
        end
        mLast = pos;
      end
      if (pos == WIN - 1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "missing expectation", winIdx, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(mLead == e.nLead, e.tag, "lead pulse count (R6)", mLead, e.nLead);
          check(mLag == e.nLag, e.tag, "lag pulse count (R6)", mLag, e.nLag);
          if (e.first >= 0)
            check(mFirst == e.first, e.tag, "first pulse cycle (R8)", mFirst, e.first);
          if (e.gap > 0) begin
            check(mMinGap == e.gap, e.tag, "min pulse gap (R8)", mMinGap, e.gap);
            check(mMaxGap == e.gap, e.tag, "max pulse gap (R8)", mMaxGap, e.gap);
          end
        end
        winIdx++;
        mLead = 0; mLag = 0; mFirst = -1; mLast = -1; mMinGap = 9999; mMaxGap = 0;
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs low while reset held
    repeat (3) @(negedge clk);
    check(!corrLead && !corrLag, "R1", "outputs during reset",
          int'(corrLead) + int'(corrLag), 0);
    expQ.push_back(mkExp(0, "R1"));
    rst_n = 1'b1;
    // W0: nine leads plus one on the window's last cycle -> +10 (R2 R4)
    runWindow(9, 0, 0, 1'b1, "R2 R4");
    // W1: +54 -> 64, spacing 8 (R8)
    runWindow(54, 0, 0, 1'b0, "R8");
    // W2: -63 -> 1, single pulse at cycle 256 (R8)
    runWindow(0, 63, 0, 1'b0, "R8");
    // W3: 3 lags, 5 cycles with both high ignored -> -2 (R2 R6)
    runWindow(0, 3, 5, 1'b0, "R2 R6");
    // W4: lead every cycle, net saturates at +127 -> 125 (R3)
    runWindow(WIN, 0, 0, 1'b0, "R3");
    // W5: again +127 -> estimate saturates at 127 (R5)
    runWindow(WIN, 0, 0, 1'b0, "R5");
    // W6: lag every cycle -> 0, no pulses (R3 R6)
    runWindow(0, WIN, 0, 1'b0, "R3 R6");
    // W7: -127 -> lag stream of 127 (R6)
    runWindow(0, WIN, 0, 1'b0, "R6");
    // W8: negative saturation holds at -127 (R5)
    runWindow(0, WIN, 0, 1'b0, "R5");
    // W9: idle window, estimate persists (R4)
    runWindow(0, 0, 0, 1'b0, "R4");
    // W10: idle
    runWindow(0, 0, 0, 1'b0, "R4");
    repeat (2) @(negedge clk);
    check(winIdx == 11, "R2", "windows observed", winIdx, 11);
    check(bothErr == 0, "R7", "cycles with both outputs high", bothErr, 0);
    check(widthErr == 0, "R9", "pulses wider than one cycle", widthErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule